// File: doc/BRIEF.md
# Out-of-Band Packet Word Framer

This block sits between a local byte-oriented producer/consumer and a pair of 32-bit word buffers that a serial link controller reads and fills. On the send side, a local agent announces a payload length and streams bytes. The block packs them four to a word, least significant lane first, into the words that follow a header word. It then builds the header and raises a ready-for-pickup flag. That flag stays up until the link side reports that the buffer has been taken.

On the receive side, the local agent arms the block, which raises a buffer-empty flag. The link side may then write words into the receive buffer and announce a complete packet. The block decodes the length from the header word, checks it against the payload ceiling, and streams the payload bytes back out in order. A link error level blocks reception. The two handshake flags are never raised in the same clock cycle.

Lengths above the payload ceiling are refused on both paths. A send that is refused, whether for size or because the send buffer is still occupied, writes nothing.

Top module: `oob_framer`

## Requirements
- R1: The send header word (word 0) carries length bits 7:0 in bits 31:24, tag 0 in bits 23:20, length bits 11:8 in bits 19:16, cycle code 0x21 in bits 15:8, and (length + 3) modulo 256 in bits 7:0.
- R2: Payload byte i lands in send word 1 + i/4, in bits 8*(i mod 4)+7 down to 8*(i mod 4). Unused upper lanes of the final word are zero.
- R3: A send start with length above MAX_PAYLOAD (default 64) raises `tx_err` for one cycle, visible the cycle after the start. No buffer word changes, and `tx_avail` stays low.
- R4: A send start while a packet is being filled or is awaiting pickup raises `tx_err` for one cycle. The buffer contents and `tx_avail` are unchanged.
- R5: `tx_ready` is high while bytes are being accepted. `tx_avail` rises two cycles after the cycle that delivers the last byte (or after the start, for length 0). It stays high until `tx_consumed` is sampled, and clears on the next cycle.
- R6: After `rx_commit` is sampled while `rx_free` is high, the length is decoded as {word0[19:16], word0[31:24]}. The payload bytes come out on `rx_byte` with `rx_byte_valid`, taking byte i from word 1 + i/4, lane i mod 4. `rx_done` is high with the last byte (alone for length 0), and `rx_len` holds the decoded length.
- R7: A received length above MAX_PAYLOAD raises `rx_err` for one cycle, and no byte is emitted.
- R8: While `rx_free` is low, `rx_commit` and receive-buffer writes have no effect.
- R9: An arm request while `rx_bus_err` is high is refused with a one-cycle `rx_err`, and `rx_free` stays low. A commit while `rx_bus_err` is high is ignored, and `rx_free` stays high.
- R10: `rx_free` never rises in the same cycle as `tx_avail`. An arm request that would do so takes effect one cycle later.
- R11: After reset, `tx_avail`, `tx_ready`, `tx_err`, `rx_free`, `rx_byte_valid`, `rx_done` and `rx_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Begin a send packet |
| tx_len | input | 12 | Send payload length in bytes |
| tx_byte_valid | input | 1 | Send byte strobe |
| tx_byte | input | 8 | Send payload byte |
| tx_ready | output | 1 | Block is accepting send bytes |
| tx_err | output | 1 | Send start refused |
| tx_rd_idx | input | IDX_W | Send buffer word index, link side |
| tx_rd_word | output | 32 | Send buffer word at `tx_rd_idx` |
| tx_avail | output | 1 | Send packet waiting for pickup |
| tx_consumed | input | 1 | Link side has taken the send packet |
| rx_arm | input | 1 | Local side requests a receive |
| rx_bus_err | input | 1 | Link error level |
| rx_free | output | 1 | Receive buffer empty and open |
| rx_wr_en | input | 1 | Receive buffer write strobe |
| rx_wr_idx | input | IDX_W | Receive buffer word index |
| rx_wr_data | input | 32 | Receive buffer word data |
| rx_commit | input | 1 | Link side has filled a packet |
| rx_byte_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received payload byte |
| rx_done | output | 1 | Received packet complete |
| rx_len | output | 12 | Decoded received length |
| rx_err | output | 1 | Receive refused or oversize |

## Verification
On every cycle, the bound checker enforces the flag rules: `tx_avail` holds until pickup and then drops, it never overlaps `tx_ready`, and it never rises together with `rx_free`. The checker also requires that `rx_free` survives a commit under a link error, that no byte appears while armed or alongside an error, and that every send error follows a start. Only the directed scenarios can show that the header fields, the lane order and the zeroed tail are correct, and that the decoded length and byte order come back intact. They also show that refused sends leave earlier buffer words untouched and that writes made while the buffer is closed do not leak into the next packet.

// File: rtl/oob_pkg.sv
package oob_pkg;
  localparam int unsigned OOB_WORD_W = 32;
  localparam int unsigned OOB_LEN_W  = 12;
  localparam logic [7:0] OOB_CYCLE_GET = 8'h21;
  localparam logic [3:0] OOB_TAG_DFLT  = 4'h0;
  localparam logic [OOB_LEN_W-1:0] OOB_HDR_EXTRA = 12'd3;

  typedef enum logic [1:0] {
    TXS_IDLE,
    TXS_FILL,
    TXS_HDR,
    TXS_HELD
  } tx_state_e;

  typedef enum logic [1:0] {
    RXS_IDLE,
    RXS_OPEN,
    RXS_PARSE,
    RXS_EMIT
  } rx_state_e;

  // Send header: split length, tag, cycle code, size-plus-three byte.
  function automatic logic [OOB_WORD_W-1:0] build_hdr(input logic [OOB_LEN_W-1:0] len);
    logic [OOB_LEN_W-1:0] sz;
    sz = len + OOB_HDR_EXTRA;
    return {len[7:0], OOB_TAG_DFLT, len[11:8], OOB_CYCLE_GET, sz[7:0]};
  endfunction

  function automatic logic [OOB_LEN_W-1:0] parse_len(input logic [OOB_WORD_W-1:0] w);
    return {w[19:16], w[31:24]};
  endfunction
endpackage

// File: rtl/oob_rst_sync.sv
module oob_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/oob_word_buf.sv
module oob_word_buf #(
  parameter int unsigned DEPTH = 17,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        mem_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_en && (wr_idx == IDX_W'(e))) begin
          mem_q[e] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_idx == IDX_W'(e)) begin
        rd_data = mem_q[e];
      end
    end
  end
endmodule

// File: rtl/oob_tx_packer.sv
module oob_tx_packer
  import oob_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 64,
  parameter int unsigned IDX_W       = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [OOB_LEN_W-1:0]  len,
  input  logic                  byte_valid,
  input  logic [7:0]            byte_in,
  input  logic                  consumed,
  output logic                  ready,
  output logic                  avail,
  output logic                  err,
  output logic                  hdr_phase,
  output logic                  buf_wr_en,
  output logic [IDX_W-1:0]      buf_wr_idx,
  output logic [OOB_WORD_W-1:0] buf_wr_data
);
  localparam logic [OOB_LEN_W-1:0] MAX_LEN = OOB_LEN_W'(MAX_PAYLOAD);

  tx_state_e              state_q, state_d;
  logic [OOB_LEN_W-1:0]   len_q, len_d;
  logic [OOB_LEN_W-1:0]   cnt_q, cnt_d;
  logic [OOB_WORD_W-1:0]  acc_q, acc_d;
  logic                   err_q, err_d;
  logic [1:0]             lane;
  logic [OOB_WORD_W-1:0]  merged;
  logic                   last_byte;

  assign lane      = cnt_q[1:0];
  assign merged    = acc_q | (OOB_WORD_W'(byte_in) << {lane, 3'b000});
  assign last_byte = (cnt_q == (len_q - OOB_LEN_W'(1)));

  always_comb begin
    state_d     = state_q;
    len_d       = len_q;
    cnt_d       = cnt_q;
    acc_d       = acc_q;
    err_d       = 1'b0;
    buf_wr_en   = 1'b0;
    buf_wr_idx  = '0;
    buf_wr_data = '0;
    unique case (state_q)
      TXS_IDLE: begin
        if (start) begin
          if (len > MAX_LEN) begin
            err_d = 1'b1;
          end else begin
            len_d   = len;
            cnt_d   = '0;
            acc_d   = '0;
            state_d = (len == '0) ? TXS_HDR : TXS_FILL;
          end
        end
      end
      TXS_FILL: begin
        err_d = start;
        if (byte_valid) begin
          cnt_d = cnt_q + OOB_LEN_W'(1);
          if ((lane == 2'd3) || last_byte) begin
            buf_wr_en   = 1'b1;
            buf_wr_idx  = IDX_W'(cnt_q >> 2) + IDX_W'(1);
            buf_wr_data = merged;
            acc_d       = '0;
          end else begin
            acc_d = merged;
          end
          if (last_byte) begin
            state_d = TXS_HDR;
          end
        end
      end
      TXS_HDR: begin
        err_d       = start;
        buf_wr_en   = 1'b1;
        buf_wr_idx  = '0;
        buf_wr_data = build_hdr(len_q);
        state_d     = TXS_HELD;
      end
      TXS_HELD: begin
        err_d = start;
        if (consumed) begin
          state_d = TXS_IDLE;
        end
      end
      default: state_d = TXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      err_q   <= err_d;
    end
  end

  assign ready     = (state_q == TXS_FILL);
  assign avail     = (state_q == TXS_HELD);
  assign hdr_phase = (state_q == TXS_HDR);
  assign err       = err_q;
endmodule

// File: rtl/oob_rx_unpacker.sv
module oob_rx_unpacker
  import oob_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 64,
  parameter int unsigned IDX_W       = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic                  block,
  input  logic                  bus_err,
  input  logic                  commit,
  input  logic [OOB_WORD_W-1:0] buf_rd_data,
  output logic [IDX_W-1:0]      buf_rd_idx,
  output logic                  free,
  output logic                  byte_valid,
  output logic [7:0]            byte_out,
  output logic                  done,
  output logic [OOB_LEN_W-1:0]  len_out,
  output logic                  err
);
  localparam logic [OOB_LEN_W-1:0] MAX_LEN = OOB_LEN_W'(MAX_PAYLOAD);

  rx_state_e             state_q, state_d;
  logic                  pend_q, pend_d;
  logic [OOB_LEN_W-1:0]  len_q, len_d;
  logic [OOB_LEN_W-1:0]  cnt_q, cnt_d;
  logic [7:0]            byte_q, byte_d;
  logic                  valid_q, valid_d;
  logic                  done_q, done_d;
  logic                  err_q, err_d;
  logic                  arm_req;
  logic [OOB_LEN_W-1:0]  hdr_len;

  assign arm_req = arm | pend_q;
  assign hdr_len = parse_len(buf_rd_data);

  always_comb begin
    state_d    = state_q;
    pend_d     = 1'b0;
    len_d      = len_q;
    cnt_d      = cnt_q;
    byte_d     = byte_q;
    valid_d    = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    buf_rd_idx = '0;
    unique case (state_q)
      RXS_IDLE: begin
        if (arm_req) begin
          if (block) begin
            pend_d = 1'b1;
          end else if (bus_err) begin
            err_d = 1'b1;
          end else begin
            state_d = RXS_OPEN;
          end
        end
      end
      RXS_OPEN: begin
        if (commit && !bus_err) begin
          state_d = RXS_PARSE;
        end
      end
      RXS_PARSE: begin
        buf_rd_idx = '0;
        if (hdr_len > MAX_LEN) begin
          err_d   = 1'b1;
          state_d = RXS_IDLE;
        end else begin
          len_d = hdr_len;
          cnt_d = '0;
          if (hdr_len == '0) begin
            done_d  = 1'b1;
            state_d = RXS_IDLE;
          end else begin
            state_d = RXS_EMIT;
          end
        end
      end
      RXS_EMIT: begin
        buf_rd_idx = IDX_W'(cnt_q >> 2) + IDX_W'(1);
        byte_d     = 8'(buf_rd_data >> {cnt_q[1:0], 3'b000});
        valid_d    = 1'b1;
        cnt_d      = cnt_q + OOB_LEN_W'(1);
        if (cnt_q == (len_q - OOB_LEN_W'(1))) begin
          done_d  = 1'b1;
          state_d = RXS_IDLE;
        end
      end
      default: state_d = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RXS_IDLE;
      pend_q  <= 1'b0;
      len_q   <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign free       = (state_q == RXS_OPEN);
  assign byte_valid = valid_q;
  assign byte_out   = byte_q;
  assign done       = done_q;
  assign len_out    = len_q;
  assign err        = err_q;
endmodule

// File: rtl/oob_framer.sv
module oob_framer
  import oob_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 64,
  parameter int unsigned NWORDS      = (MAX_PAYLOAD + 3) / 4 + 1,
  parameter int unsigned IDX_W       = $clog2(NWORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_start,
  input  logic [OOB_LEN_W-1:0]  tx_len,
  input  logic                  tx_byte_valid,
  input  logic [7:0]            tx_byte,
  output logic                  tx_ready,
  output logic                  tx_err,
  input  logic [IDX_W-1:0]      tx_rd_idx,
  output logic [OOB_WORD_W-1:0] tx_rd_word,
  output logic                  tx_avail,
  input  logic                  tx_consumed,
  input  logic                  rx_arm,
  input  logic                  rx_bus_err,
  output logic                  rx_free,
  input  logic                  rx_wr_en,
  input  logic [IDX_W-1:0]      rx_wr_idx,
  input  logic [OOB_WORD_W-1:0] rx_wr_data,
  input  logic                  rx_commit,
  output logic                  rx_byte_valid,
  output logic [7:0]            rx_byte,
  output logic                  rx_done,
  output logic [OOB_LEN_W-1:0]  rx_len,
  output logic                  rx_err
);
  logic                  rst_n_s;
  logic                  tx_hdr_phase;
  logic                  txb_wr_en;
  logic [IDX_W-1:0]      txb_wr_idx;
  logic [OOB_WORD_W-1:0] txb_wr_data;
  logic [IDX_W-1:0]      rxb_rd_idx;
  logic [OOB_WORD_W-1:0] rxb_rd_data;
  logic                  rxb_wr_gate;

  oob_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  oob_tx_packer #(.MAX_PAYLOAD(MAX_PAYLOAD), .IDX_W(IDX_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (tx_start),
    .len         (tx_len),
    .byte_valid  (tx_byte_valid),
    .byte_in     (tx_byte),
    .consumed    (tx_consumed),
    .ready       (tx_ready),
    .avail       (tx_avail),
    .err         (tx_err),
    .hdr_phase   (tx_hdr_phase),
    .buf_wr_en   (txb_wr_en),
    .buf_wr_idx  (txb_wr_idx),
    .buf_wr_data (txb_wr_data)
  );

  oob_word_buf #(.DEPTH(NWORDS), .WIDTH(OOB_WORD_W), .IDX_W(IDX_W)) u_txbuf (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (txb_wr_en),
    .wr_idx  (txb_wr_idx),
    .wr_data (txb_wr_data),
    .rd_idx  (tx_rd_idx),
    .rd_data (tx_rd_word)
  );

  // Link-side writes land only while the receive buffer is open.
  assign rxb_wr_gate = rx_wr_en & rx_free;

  oob_word_buf #(.DEPTH(NWORDS), .WIDTH(OOB_WORD_W), .IDX_W(IDX_W)) u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (rxb_wr_gate),
    .wr_idx  (rx_wr_idx),
    .wr_data (rx_wr_data),
    .rd_idx  (rxb_rd_idx),
    .rd_data (rxb_rd_data)
  );

  // The header-write cycle is the one before tx_avail rises, so an arm
  // request there is held back a cycle to keep the two flags apart.
  oob_rx_unpacker #(.MAX_PAYLOAD(MAX_PAYLOAD), .IDX_W(IDX_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .arm         (rx_arm),
    .block       (tx_hdr_phase),
    .bus_err     (rx_bus_err),
    .commit      (rx_commit),
    .buf_rd_data (rxb_rd_data),
    .buf_rd_idx  (rxb_rd_idx),
    .free        (rx_free),
    .byte_valid  (rx_byte_valid),
    .byte_out    (rx_byte),
    .done        (rx_done),
    .len_out     (rx_len),
    .err         (rx_err)
  );
endmodule

// File: rtl/oob_framer_chk.sv
module oob_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_start,
  input logic tx_ready,
  input logic tx_err,
  input logic tx_avail,
  input logic tx_consumed,
  input logic rx_bus_err,
  input logic rx_free,
  input logic rx_byte_valid,
  input logic rx_err
);
  assert_err_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> $past(tx_start));

  assert_avail_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_avail && !tx_consumed) |=> tx_avail);

  assert_avail_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_avail && tx_consumed) |=> !tx_avail);

  assert_fill_not_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && tx_avail));

  assert_no_bytes_while_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |-> !rx_free);

  assert_err_no_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !rx_byte_valid);

  assert_buserr_keeps_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_free && rx_bus_err) |=> rx_free);

  assert_flags_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(tx_avail) && $rose(rx_free)));
endmodule

bind oob_framer oob_framer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_start      (tx_start),
  .tx_ready      (tx_ready),
  .tx_err        (tx_err),
  .tx_avail      (tx_avail),
  .tx_consumed   (tx_consumed),
  .rx_bus_err    (rx_bus_err),
  .rx_free       (rx_free),
  .rx_byte_valid (rx_byte_valid),
  .rx_err        (rx_err)
);

// File: tb/oob_framer_tb.sv
`timescale 1ns/1ps
module oob_framer_tb;
  localparam int MAXP  = 64;
  localparam int NW    = (MAXP + 3) / 4 + 1;
  localparam int IDX_W = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_start = 1'b0;
  logic [11:0] tx_len = '0;
  logic tx_byte_valid = 1'b0;
  logic [7:0] tx_byte = '0;
  logic tx_ready, tx_err, tx_avail;
  logic [IDX_W-1:0] tx_rd_idx = '0;
  logic [31:0] tx_rd_word;
  logic tx_consumed = 1'b0;
  logic rx_arm = 1'b0;
  logic rx_bus_err = 1'b0;
  logic rx_free;
  logic rx_wr_en = 1'b0;
  logic [IDX_W-1:0] rx_wr_idx = '0;
  logic [31:0] rx_wr_data = '0;
  logic rx_commit = 1'b0;
  logic rx_byte_valid, rx_done, rx_err;
  logic [7:0] rx_byte;
  logic [11:0] rx_len;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  oob_framer u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_start(tx_start), .tx_len(tx_len), .tx_byte_valid(tx_byte_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .tx_err(tx_err),
    .tx_rd_idx(tx_rd_idx), .tx_rd_word(tx_rd_word), .tx_avail(tx_avail),
    .tx_consumed(tx_consumed), .rx_arm(rx_arm), .rx_bus_err(rx_bus_err),
    .rx_free(rx_free), .rx_wr_en(rx_wr_en), .rx_wr_idx(rx_wr_idx),
    .rx_wr_data(rx_wr_data), .rx_commit(rx_commit),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_done(rx_done),
    .rx_len(rx_len), .rx_err(rx_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  function automatic logic [31:0] data_word(input int len, input int seed, input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int idx = (w - 1) * 4 + k;
      if (idx < len) r |= 32'(pat(seed, idx)) << (8 * k);
    end
    return r;
  endfunction

  function automatic logic [31:0] tx_hdr_exp(input int len);
    logic [11:0] l = 12'(len);
    logic [7:0] s = 8'(len + 3);
    return {l[7:0], 4'h0, l[11:8], 8'h21, s};
  endfunction

  function automatic logic [31:0] rx_hdr(input int len);
    logic [11:0] l = 12'(len);
    return {l[7:0], 4'h0, l[11:8], 8'h21, 8'h00};
  endfunction

  task automatic read_tx(input int idx, output logic [31:0] w);
    tx_rd_idx = IDX_W'(idx);
    #1;
    w = tx_rd_word;
  endtask

  // R1 R2 R5: stream a packet and inspect the send buffer.
  task automatic t_tx_send(input int len, input int seed);
    logic [31:0] w;
    @(negedge clk);
    tx_start = 1'b1; tx_len = 12'(len);
    @(negedge clk);
    tx_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i == 0) check("R5 ready during fill", 32'(tx_ready), 32'd1);
      tx_byte_valid = 1'b1; tx_byte = pat(seed, i);
      @(negedge clk);
    end
    tx_byte_valid = 1'b0;
    check("R5 avail not yet", 32'(tx_avail), 32'd0);
    @(negedge clk);
    check("R5 avail raised", 32'(tx_avail), 32'd1);
    read_tx(0, w);
    check("R1 header word", w, tx_hdr_exp(len));
    for (int k = 1; k <= (len + 3) / 4; k++) begin
      read_tx(k, w);
      check("R2 data word", w, data_word(len, seed, k));
    end
  endtask

  task automatic t_tx_consume();
    @(negedge clk);
    tx_consumed = 1'b1;
    @(negedge clk);
    tx_consumed = 1'b0;
    check("R5 avail cleared by pickup", 32'(tx_avail), 32'd0);
  endtask

  task automatic t_tx_oversize();
    logic [31:0] w0, w1, a0, a1;
    read_tx(0, w0); read_tx(1, w1);
    @(negedge clk);
    tx_start = 1'b1; tx_len = 12'(MAXP + 1);
    @(negedge clk);
    tx_start = 1'b0;
    check("R3 oversize error", 32'(tx_err), 32'd1);
    check("R3 no fill", 32'(tx_ready), 32'd0);
    @(negedge clk);
    check("R3 error one cycle", 32'(tx_err), 32'd0);
    repeat (2) @(negedge clk);
    check("R3 avail stays low", 32'(tx_avail), 32'd0);
    read_tx(0, a0); read_tx(1, a1);
    check("R3 word0 untouched", a0, w0);
    check("R3 word1 untouched", a1, w1);
  endtask

  task automatic t_tx_busy();
    logic [31:0] w0, w1, a0, a1;
    t_tx_send(6, 40);
    read_tx(0, w0); read_tx(1, w1);
    @(negedge clk);
    tx_start = 1'b1; tx_len = 12'd3;
    @(negedge clk);
    tx_start = 1'b0;
    check("R4 busy error", 32'(tx_err), 32'd1);
    @(negedge clk);
    check("R4 avail unchanged", 32'(tx_avail), 32'd1);
    check("R4 no fill", 32'(tx_ready), 32'd0);
    read_tx(0, a0); read_tx(1, a1);
    check("R4 word0 untouched", a0, w0);
    check("R4 word1 untouched", a1, w1);
    t_tx_consume();
  endtask

  task automatic rx_arm_now(input logic expect_free);
    @(negedge clk);
    rx_arm = 1'b1;
    @(negedge clk);
    rx_arm = 1'b0;
    check("R9 free after arm", 32'(rx_free), 32'(expect_free));
  endtask

  task automatic rx_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    rx_wr_en = 1'b1; rx_wr_idx = IDX_W'(idx); rx_wr_data = d;
    @(negedge clk);
    rx_wr_en = 1'b0;
  endtask

  task automatic rx_load(input int len, input int seed);
    rx_write(0, rx_hdr(len));
    for (int k = 1; k <= (len + 3) / 4; k++) rx_write(k, data_word(len, seed, k));
  endtask

  task automatic rx_commit_now();
    @(negedge clk);
    rx_commit = 1'b1;
    @(negedge clk);
    rx_commit = 1'b0;
  endtask

  task automatic rx_collect(input int len, input int seed, input string req);
    int got = 0;
    bit seen_done = 1'b0;
    for (int c = 0; c < 90 && !seen_done; c++) begin
      @(negedge clk);
      if (rx_byte_valid) begin
        check({req, " byte"}, 32'(rx_byte), 32'(pat(seed, got)));
        got++;
      end
      if (rx_done) seen_done = 1'b1;
    end
    check({req, " done seen"}, 32'(seen_done), 32'd1);
    check({req, " byte count"}, 32'(got), 32'(len));
    check({req, " length"}, 32'(rx_len), 32'(len));
  endtask

  task automatic t_rx_packet(input int len, input int seed);
    rx_arm_now(1'b1);
    rx_load(len, seed);
    rx_commit_now();
    check("R6 free drops on commit", 32'(rx_free), 32'd0);
    rx_collect(len, seed, "R6");
  endtask

  task automatic t_rx_oversize();
    bit any_byte = 1'b0;
    rx_arm_now(1'b1);
    rx_write(0, rx_hdr(256));
    rx_commit_now();
    @(negedge clk);
    check("R7 oversize error", 32'(rx_err), 32'd1);
    for (int c = 0; c < 6; c++) begin
      if (rx_byte_valid) any_byte = 1'b1;
      @(negedge clk);
    end
    check("R7 no bytes", 32'(any_byte), 32'd0);
  endtask

  task automatic t_rx_closed();
    bit any = 1'b0;
    t_rx_packet(5, 90);
    rx_commit_now();
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (rx_byte_valid || rx_done || rx_err) any = 1'b1;
    end
    check("R8 commit ignored when closed", 32'(any), 32'd0);
    rx_write(0, rx_hdr(9));
    rx_arm_now(1'b1);
    rx_commit_now();
    rx_collect(5, 90, "R8 closed write ignored");
  endtask

  task automatic t_rx_buserr();
    bit any = 1'b0;
    rx_bus_err = 1'b1;
    @(negedge clk);
    rx_arm = 1'b1;
    @(negedge clk);
    rx_arm = 1'b0;
    check("R9 arm refused error", 32'(rx_err), 32'd1);
    check("R9 arm refused free", 32'(rx_free), 32'd0);
    rx_bus_err = 1'b0;
    rx_arm_now(1'b1);
    rx_load(3, 17);
    rx_bus_err = 1'b1;
    rx_commit_now();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (rx_byte_valid) any = 1'b1;
    end
    check("R9 commit ignored keeps free", 32'(rx_free), 32'd1);
    check("R9 no bytes under error", 32'(any), 32'd0);
    rx_bus_err = 1'b0;
    rx_commit_now();
    rx_collect(3, 17, "R9 after error clears");
  endtask

  task automatic t_flag_apart();
    @(negedge clk);
    tx_start = 1'b1; tx_len = 12'd2;
    @(negedge clk);
    tx_start = 1'b0;
    tx_byte_valid = 1'b1; tx_byte = 8'hA1;
    @(negedge clk);
    tx_byte = 8'hB2;
    @(negedge clk);
    tx_byte_valid = 1'b0;
    rx_arm = 1'b1;
    @(negedge clk);
    rx_arm = 1'b0;
    check("R10 avail rises", 32'(tx_avail), 32'd1);
    check("R10 free held back", 32'(rx_free), 32'd0);
    @(negedge clk);
    check("R10 free one cycle later", 32'(rx_free), 32'd1);
    t_tx_consume();
    rx_load(1, 3);
    rx_commit_now();
    rx_collect(1, 3, "R10 deferred arm");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 avail reset", 32'(tx_avail), 32'd0);
    check("R11 ready reset", 32'(tx_ready), 32'd0);
    check("R11 tx_err reset", 32'(tx_err), 32'd0);
    check("R11 free reset", 32'(rx_free), 32'd0);
    check("R11 rx outputs reset", {29'd0, rx_byte_valid, rx_done, rx_err}, 32'd0);

    t_tx_send(5, 1);   t_tx_consume();
    t_tx_send(8, 50);  t_tx_consume();
    t_tx_send(MAXP, 9); t_tx_consume();
    t_tx_send(0, 0);   t_tx_consume();
    t_tx_oversize();
    t_tx_busy();

    t_rx_packet(7, 21);
    t_rx_packet(MAXP, 200);
    t_rx_packet(0, 0);
    t_rx_oversize();
    t_rx_closed();
    t_rx_buserr();
    t_flag_apart();

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule